// File: doc/BRIEF.md
# UART FIFO Control with Receive Character Timeout

This block holds the FIFO control state of a 16550-style serial port together with its two 16-byte queues. The receive queue is filled by the deserializer and drained by host reads. The transmit queue is filled by host writes and drained by the serializer. A byte-wide control write selects whether the queues are in use, which receive fill level raises the trigger output, and which queues are flushed. Baud generation and serial framing sit outside the block.

When the queues are off, each direction falls back to a single holding byte. When they are on, a character-timeout flag tells the host that bytes are waiting in the receive queue but nothing has arrived or been read for four character times. The character time is given in clock cycles on an input. A value of zero stops the timeout from firing.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: The receive queue holds at most 16 bytes. A push into a full receive queue is dropped, the count stays the same, and `rx_overrun` is high for the one cycle after that push.
- R2: With the queues on, `rx_trig` is high when `rx_count` is at or above the level chosen by control bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With the queues off, `rx_trig` equals `data_ready`.
- R3: A control write stores only bits 7, 6, 3 and 0 of the written byte, as seen on `fcr_q`. Bits 1 and 2 always read as zero.
- R4: Writing control bit 1 empties the receive queue, and writing bit 2 empties the transmit queue. Each flush leaves the other queue untouched.
- R5: A control write that changes bit 0 (queue enable) empties both queues, whatever bits 1 and 2 hold.
- R6: With the queues on, `timeout_pending` rises 4×`char_time` cycles after the last receive push or read, if the receive queue stayed non-empty the whole time.
- R7: A receive push or a receive read restarts the timeout count, and a read also clears `timeout_pending`.
- R8: A receive-queue flush clears `timeout_pending` and the count.
- R9: `data_ready` is high exactly when the receive queue holds a byte. `tx_empty` is high exactly when the transmit queue holds none.
- R10: Bytes leave each queue in arrival order. `rx_rdata` and `tx_rdata` show the oldest byte.
- R11: With the queues off (bit 0 clear, the reset state), each direction holds one byte. A second push is dropped (and flags `rx_overrun` on receive), a read clears `data_ready`, and `timeout_pending` never rises.
- R12: A read of an empty receive queue shows 0x00 on `rx_rdata` and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcr_we | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control byte written |
| char_time | input | 16 | Clock cycles per character |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a received byte |
| rx_rdata | output | 8 | Oldest received byte, 0x00 when empty |
| tx_push | input | 1 | Host writes a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Serializer takes a byte |
| tx_rdata | output | 8 | Oldest byte to send, 0x00 when empty |
| rx_count | output | 5 | Receive queue fill |
| tx_count | output | 5 | Transmit queue fill |
| data_ready | output | 1 | Receive queue non-empty |
| tx_empty | output | 1 | Transmit queue empty |
| rx_trig | output | 1 | Receive fill at or above trigger level |
| rx_overrun | output | 1 | A receive push was dropped last cycle |
| timeout_pending | output | 1 | Character timeout flag |
| fcr_q | output | 8 | Stored control bits |

## Verification
The assertions assume the serializer and host use single-cycle strobes sampled at the clock edge. They also assume that `char_time` changes only while the receive queue is empty. The stimulus changes `char_time` once, during reset, and drives every strobe for exactly one cycle from the negative edge. A flush is never issued in the same cycle as a push or read, so the flush-priority paths are reached only through the enable toggle and the explicit flush bits.

// File: rtl/ufc_pkg.sv
// Shared helpers for the UART FIFO control block.
// Assumes the trigger encoding is fixed at two bits regardless of depth.
package ufc_pkg;
    // Maps the two trigger-select bits to a receive fill threshold.
    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/ufc_fifo.sv
// Synchronous byte queue with a run-time fill limit and a flush input.
// Assumes DEPTH is a power of two so the pointers wrap on their own.
// A push above the limit is dropped and reported on `drop`.
module ufc_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic [$clog2(DEPTH):0]   limit,
    input  logic                     push,
    input  logic [DW-1:0]            wdata,
    input  logic                     pop,
    output logic [DW-1:0]            rdata,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          accept, take;

    // Decide whether this cycle's push and pop take effect.
    always_comb begin
        accept = push && (count < limit);
        take   = pop && (count != '0);
        drop   = push && !accept && !clr;
        rdata  = (count != '0) ? mem[rd_ptr] : '0;
    end

    // Pointer and fill tracking, with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + PW'(1);
            if (take)   rd_ptr <= rd_ptr + PW'(1);
            count <= count + CW'(accept) - CW'(take);
        end
    end

    // Storage write for accepted bytes.
    always_ff @(posedge clk) begin
        if (rst_n && !clr && accept) mem[wr_ptr] <= wdata;
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_empty_read_static_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && pop && !push && count == '0) |=> (count == '0));
endmodule

// File: rtl/ufc_timeout.sv
// Receive character-timeout tracker.
// Counts idle cycles while the receive queue holds data and raises
// `pending` after four character times. Assumes char_time is steady
// while data waits. A zero char_time never fires.
module ufc_timeout #(
    parameter int CHAR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              restart,
    input  logic              read,
    input  logic              nonempty,
    input  logic [CHAR_W-1:0] char_time,
    output logic              pending
);
    localparam int TW = CHAR_W + 2;

    logic [TW-1:0] cnt;
    logic [TW-1:0] limit;

    // Four character times expressed in clock cycles.
    always_comb limit = {char_time, 2'b00};

    // Idle counter and pending flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else if (restart) begin
            cnt <= '0;
            if (read) pending <= 1'b0;
        end else if (!nonempty) begin
            cnt <= '0;
        end else if (!pending) begin
            cnt <= cnt + TW'(1);
            if (limit != '0 && cnt + TW'(1) == limit) pending <= 1'b1;
        end
    end

    assert_pending_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> nonempty);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (read && !clr) |=> !pending);

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pending);
endmodule

// File: rtl/uart_fifo_ctrl.sv
// FIFO control for a 16550-style serial port: control register,
// receive and transmit queues, trigger detection and character timeout.
// Assumes single-cycle strobes from the host and serializer.
module uart_fifo_ctrl #(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int CHAR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fcr_we,
    input  logic [7:0]             fcr_wdata,
    input  logic [CHAR_W-1:0]      char_time,
    input  logic                   rx_push,
    input  logic [DW-1:0]          rx_data,
    input  logic                   rx_pop,
    output logic [DW-1:0]          rx_rdata,
    input  logic                   tx_push,
    input  logic [DW-1:0]          tx_data,
    input  logic                   tx_pop,
    output logic [DW-1:0]          tx_rdata,
    output logic [$clog2(DEPTH):0] rx_count,
    output logic [$clog2(DEPTH):0] tx_count,
    output logic                   data_ready,
    output logic                   tx_empty,
    output logic                   rx_trig,
    output logic                   rx_overrun,
    output logic                   timeout_pending,
    output logic [7:0]             fcr_q
);
    import ufc_pkg::*;

    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [7:0] KEEP_MASK = 8'hC9;

    logic          en, toggle, flush_rx, flush_tx, rx_drop, tx_drop;
    logic [CW-1:0] lim;

    // Decode control writes into flush requests and the active depth.
    always_comb begin
        en       = fcr_q[0];
        toggle   = fcr_we && (fcr_wdata[0] != en);
        flush_rx = fcr_we && (fcr_wdata[1] || toggle);
        flush_tx = fcr_we && (fcr_wdata[2] || toggle);
        lim      = en ? CW'(DEPTH) : CW'(1);
    end

    // Control register keeps only its sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      fcr_q <= '0;
        else if (fcr_we) fcr_q <= fcr_wdata & KEEP_MASK;
    end

    // One-cycle overrun pulse for a dropped receive byte.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_overrun <= 1'b0;
        else        rx_overrun <= rx_drop;
    end

    ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(flush_rx), .limit(lim),
        .push(rx_push), .wdata(rx_data), .pop(rx_pop),
        .rdata(rx_rdata), .count(rx_count), .drop(rx_drop)
    );

    ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(flush_tx), .limit(lim),
        .push(tx_push), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_rdata), .count(tx_count), .drop(tx_drop)
    );

    ufc_timeout #(.CHAR_W(CHAR_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(flush_rx || !en),
        .restart(rx_push || rx_pop), .read(rx_pop),
        .nonempty(rx_count != '0), .char_time(char_time),
        .pending(timeout_pending)
    );

    // Status flags derived from the queue fills.
    always_comb begin
        data_ready = (rx_count != '0);
        tx_empty   = (tx_count == '0);
        rx_trig    = en ? (int'(rx_count) >= trig_level(fcr_q[7:6])) : data_ready;
    end

    assert_toggle_flushes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_we && fcr_wdata[0] != fcr_q[0]) |=> (rx_count == '0 && tx_count == '0));

    assert_overrun_only_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_count) == $past(lim)));

    assert_single_byte_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fcr_q[0] |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));

    assert_tx_unused_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drop |=> ($stable(tx_count) || $past(tx_pop)));
endmodule

// File: tb/uart_fifo_ctrl_bench.sv
module uart_fifo_ctrl_bench;
    logic clk = 0;
    logic rst_n = 0;
    logic fcr_we = 0;
    logic [7:0] fcr_wdata = 0;
    logic [15:0] char_time = 16'd3;
    logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic [7:0] rx_data = 0, tx_data = 0;
    logic [7:0] rx_rdata, tx_rdata, fcr_q;
    logic [4:0] rx_count, tx_count;
    logic data_ready, tx_empty, rx_trig, rx_overrun, timeout_pending;

    int checks = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    uart_fifo_ctrl u_uart_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .char_time(char_time), .rx_push(rx_push), .rx_data(rx_data),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .tx_push(tx_push),
        .tx_data(tx_data), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_count(rx_count), .tx_count(tx_count), .data_ready(data_ready),
        .tx_empty(tx_empty), .rx_trig(rx_trig), .rx_overrun(rx_overrun),
        .timeout_pending(timeout_pending), .fcr_q(fcr_q)
    );

    // Behavioural reference state
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    logic [7:0] m_fcr = 0;
    int  m_cnt = 0;
    bit  m_pend = 0, m_ov = 0;
    bit  flr, flt;
    int  lim, rx_pre, tx_pre;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int level(logic [1:0] s);
        if (s == 2'b00) return 1;
        if (s == 2'b01) return 4;
        if (s == 2'b10) return 8;
        return 14;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_fcr = 0; m_cnt = 0; m_pend = 0; m_ov = 0;
        end else begin
            flr = 0; flt = 0; m_ov = 0;
            rx_pre = rxq.size(); tx_pre = txq.size();
            if (fcr_we) begin
                if (fcr_wdata[0] != m_fcr[0]) begin flr = 1; flt = 1; end
                if (fcr_wdata[1]) flr = 1;
                if (fcr_wdata[2]) flt = 1;
                m_fcr = fcr_wdata & 8'hC9;
            end
            lim = m_fcr[0] ? 16 : 1;
            if (flr) rxq.delete();
            else begin
                if (rx_pop && rx_pre > 0) void'(rxq.pop_front());
                if (rx_push) begin
                    if (rx_pre < lim) rxq.push_back(rx_data);
                    else m_ov = 1;
                end
            end
            if (flt) txq.delete();
            else begin
                if (tx_pop && tx_pre > 0) void'(txq.pop_front());
                if (tx_push && tx_pre < lim) txq.push_back(tx_data);
            end
            if (flr || !m_fcr[0]) begin
                m_cnt = 0; m_pend = 0;
            end else if (rx_push || rx_pop) begin
                m_cnt = 0;
                if (rx_pop) m_pend = 0;
            end else if (rx_pre == 0) begin
                m_cnt = 0;
            end else if (!m_pend) begin
                m_cnt++;
                if (char_time != 0 && m_cnt == 4 * int'(char_time)) m_pend = 1;
            end
        end
    end

    // Compare against the reference on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 rx_count", rx_count, rxq.size());
            chk("R1 rx_overrun", rx_overrun, m_ov);
            chk("R4 tx_count", tx_count, txq.size());
            chk("R9 data_ready", data_ready, rxq.size() != 0);
            chk("R9 tx_empty", tx_empty, txq.size() == 0);
            chk("R6 timeout_pending", timeout_pending, m_pend);
            chk("R10 rx_rdata", rx_rdata, rxq.size() != 0 ? rxq[0] : 0);
            chk("R10 tx_rdata", tx_rdata, txq.size() != 0 ? txq[0] : 0);
            chk("R3 fcr_q", fcr_q, m_fcr);
            chk("R2 rx_trig", rx_trig,
                m_fcr[0] ? (rxq.size() >= level(m_fcr[7:6])) : (rxq.size() != 0));
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        fcr_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    endtask
    task automatic push_rx(logic [7:0] b); rx_push = 1; rx_data = b; step(); endtask
    task automatic push_tx(logic [7:0] b); tx_push = 1; tx_data = b; step(); endtask
    task automatic pop_rx(); rx_pop = 1; step(); endtask
    task automatic pop_tx(); tx_pop = 1; step(); endtask
    task automatic wr_fcr(logic [7:0] v); fcr_we = 1; fcr_wdata = v; step(); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset rx_count R9", rx_count, 0);
        chk("reset tx_empty R9", tx_empty, 1);
        chk("reset fcr_q R3", fcr_q, 0);
        chk("reset pending R6", timeout_pending, 0);

        // R11: queues off, single holding byte
        push_rx(8'h11);
        chk("R11 one byte held", rx_count, 1);
        push_rx(8'h22);
        chk("R11 second byte dropped", rx_count, 1);
        chk("R11 overrun flagged", rx_overrun, 1);
        chk("R11 holding value", rx_rdata, 8'h11);
        idle(20);
        chk("R11 no timeout when off", timeout_pending, 0);
        pop_rx();
        chk("R11 read clears ready", data_ready, 0);
        push_tx(8'h33);
        push_tx(8'h44);
        chk("R11 tx holds one", tx_count, 1);
        pop_tx();
        chk("R11 tx empty after take", tx_empty, 1);

        // R3: stored bits
        wr_fcr(8'hFF);
        chk("R3 mask keeps C9", fcr_q, 8'hC9);
        wr_fcr(8'hC1);
        chk("R3 trigger 14 enabled", fcr_q, 8'hC1);

        // R2/R1/R10: fill to the top
        for (int i = 0; i < 13; i++) push_rx(8'(i * 3 + 1));
        chk("R2 below 14", rx_trig, 0);
        push_rx(8'(13 * 3 + 1));
        chk("R2 reaches 14", rx_trig, 1);
        push_rx(8'(14 * 3 + 1));
        push_rx(8'(15 * 3 + 1));
        chk("R1 full at 16", rx_count, 16);
        push_rx(8'hEE);
        chk("R1 overflow dropped", rx_count, 16);
        chk("R1 overrun pulse", rx_overrun, 1);
        idle(1);
        chk("R1 overrun one cycle", rx_overrun, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R10 order", rx_rdata, (i * 3 + 1) & 8'hFF);
            pop_rx();
        end
        chk("R9 drained", data_ready, 0);
        pop_rx();
        chk("R12 empty read data", rx_rdata, 0);
        chk("R12 empty read count", rx_count, 0);

        // R6/R7: timeout, limit 12 cycles
        push_rx(8'hA5);
        idle(8);
        push_rx(8'h5A);
        idle(8);
        chk("R7 push restarted", timeout_pending, 0);
        idle(3);
        chk("R6 not yet", timeout_pending, 0);
        idle(1);
        chk("R6 fires at four chars", timeout_pending, 1);
        pop_rx();
        chk("R7 read clears", timeout_pending, 0);
        chk("R7 data remains", rx_count, 1);
        idle(11);
        chk("R7 restarted after read", timeout_pending, 0);
        idle(1);
        chk("R7 fires again", timeout_pending, 1);

        // R8: receive flush cancels timeout
        wr_fcr(8'hC3);
        chk("R8 flush empties rx", rx_count, 0);
        chk("R8 flush clears pending", timeout_pending, 0);

        // R4: transmit-only flush
        for (int i = 0; i < 5; i++) push_tx(8'(8'h60 + i));
        push_rx(8'h01);
        push_rx(8'h02);
        wr_fcr(8'hC5);
        chk("R4 tx flushed", tx_count, 0);
        chk("R4 rx untouched", rx_count, 2);
        push_tx(8'h70); push_tx(8'h71); push_tx(8'h72);
        pop_tx(); pop_tx();
        chk("R9 tx not empty", tx_empty, 0);
        pop_tx();
        chk("R9 tx drained", tx_empty, 1);

        // R5: toggling enable flushes both
        push_tx(8'h80);
        wr_fcr(8'h00);
        chk("R5 rx flushed", rx_count, 0);
        chk("R5 tx flushed", tx_count, 0);
        wr_fcr(8'h41);
        chk("R5 flushed on enable", rx_count, 0);
        push_rx(1); push_rx(2); push_rx(3);
        chk("R2 below 4", rx_trig, 0);
        push_rx(4);
        chk("R2 reaches 4", rx_trig, 1);
        wr_fcr(8'h81);
        chk("R2 level 8 not met", rx_trig, 0);
        for (int i = 0; i < 4; i++) push_rx(8'(i + 5));
        chk("R2 reaches 8", rx_trig, 1);
        idle(2);
        finish_run();
    end
endmodule